// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a small processor subsystem between three power states: Run, Idle and Sleep. The instruction decoder sends a one-cycle save request with a two-bit operation code. One code selects Idle and another selects Sleep. While the request is in flight, the block gates the clocks for the CPU and the peripherals. It also switches off the main oscillator, the low-rate RC oscillator and the fail-safe clock monitor as each state requires. When the watchdog is enabled, the block sends a one-cycle clear pulse to it on entry to Sleep.

A low-power state ends on either of two wake events. The first is an interrupt that is both pending and individually enabled. The second is a watchdog time-out. On a wake event the block returns to Run and raises a one-cycle wake indication. The block also keeps the oscillator-source selection that was valid at entry. While the subsystem is asleep or idle it ignores new selections, so the original source is back in force on wake. Every output comes from a register, so every gating change lands exactly on a clock edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held, all five enables read 1, `wdt_clr` reads 0, `wake` reads 1 and `osc_sel` reads 0. Within three clock edges after release, `wake` drops to 0.
- R2: In Run, a save request with code 2'b01 (Sleep) and no enabled pending interrupt does the following from the next cycle: `cpu_clk_en`, `periph_clk_en`, `main_osc_en` and `fscm_en` read 0.
- R3: In Run, a save request with code 2'b10 (Idle) does the following from the next cycle: only `cpu_clk_en` reads 0, and the peripheral clock, both oscillators and the clock monitor stay enabled.
- R4: A save request with code 2'b00 or 2'b11 is ignored, and the block stays in Run.
- R5: `wdt_clr` pulses for exactly one cycle, in the first Sleep cycle, and only when `wdt_enable` was 1 in the request cycle. It never pulses on entry to Idle.
- R6: In Sleep, `lprc_osc_en` in each cycle equals the value `wdt_enable` had in the cycle before.
- R7: In Idle or Sleep, a wake event (any bit of `irq_pend & irq_en`, or `wdt_timeout`) puts the block in Run in the next cycle with all enables set. `wake` is 1 for exactly that one cycle.
- R8: An interrupt that is pending but not enabled does not wake the block.
- R9: A watchdog time-out while in Run has no effect.
- R10: A save request in a cycle where an enabled interrupt is already pending is dropped: no state change, no `wdt_clr`, no `wake`.
- R11: In Run, `osc_sel` takes `osc_req` one cycle later. In Idle or Sleep it holds the value of the request cycle, and it still shows that value in the first Run cycle after wake.
- R12: Asserting `rst_n` forces Run at once from any state, with `wake` set and `osc_sel` back to 0, without waiting for a clock edge.
- R13: Save requests that arrive in Idle or Sleep are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| save_req | input | 1 | One-cycle power-save request from the decoder |
| save_op | input | 2 | Operation code: 2'b01 Sleep, 2'b10 Idle, others ignored |
| irq_pend | input | N_SRC | Interrupt pending flags |
| irq_en | input | N_SRC | Per-source interrupt enables |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_enable | input | 1 | Watchdog enabled |
| osc_req | input | OSC_W | Requested oscillator source |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| lprc_osc_en | output | 1 | Low-rate RC oscillator enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| wake | output | 1 | One-cycle wake indication, also set by reset |
| osc_sel | output | OSC_W | Oscillator source in force |

## Verification
The hardest situation to reach from the ports is the wake cycle itself. There, `osc_sel` must still show the value it held on entry even though `osc_req` has since changed. At the same time, the wake pulse must last one cycle and no more. The stimulus table enters Sleep and changes `osc_req` while the block sleeps. It then sends a series of interrupts that are pending but not enabled, plus a stray request, and only then an enabled interrupt. The check in that wake cycle and the one after separates the held selection from the tracked one. A further directed step pulls reset in the middle of a Sleep cycle and samples before any edge, which proves the forced return to Run is asynchronous.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10
  } pm_state_e;

  localparam int unsigned OP_W = 2;
  localparam logic [OP_W-1:0] OP_SLEEP = 2'b01;
  localparam logic [OP_W-1:0] OP_IDLE  = 2'b10;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] irq_pend,
  input  logic [N_SRC-1:0] irq_en,
  output logic             irq_wake
);
  logic [N_SRC-1:0] src_hit;

  // one qualifying gate per interrupt source
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_hit[g] = irq_pend[g] & irq_en[g];
  end

  assign irq_wake = |src_hit;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_mode_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic [OP_W-1:0] save_op,
  input  logic            irq_wake,
  input  logic            wdt_timeout,
  output pm_state_e       state_q,
  output pm_state_e       state_nxt,
  output logic            enter_sleep,
  output logic            leave_low
);
  always_comb begin
    state_nxt   = state_q;
    enter_sleep = 1'b0;
    leave_low   = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        // an enabled pending interrupt cancels the entry attempt
        if (save_req && !irq_wake) begin
          if (save_op == OP_SLEEP) begin
            state_nxt   = PM_SLEEP;
            enter_sleep = 1'b1;
          end else if (save_op == OP_IDLE) begin
            state_nxt = PM_IDLE;
          end
        end
      end
      PM_IDLE, PM_SLEEP: begin
        if (irq_wake || wdt_timeout) begin
          state_nxt = PM_RUN;
          leave_low = 1'b1;
        end
      end
      default: state_nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_nxt;
  end
endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state_nxt,
  input  logic      wdt_enable,
  input  logic      enter_sleep,
  input  logic      leave_low,
  output logic      cpu_clk_en,
  output logic      periph_clk_en,
  output logic      main_osc_en,
  output logic      lprc_osc_en,
  output logic      fscm_en,
  output logic      wdt_clr,
  output logic      wake
);
  logic cpu_d, per_d, mosc_d, lprc_d, fscm_d, clr_d, wake_d;

  always_comb begin
    cpu_d  = (state_nxt == PM_RUN);
    per_d  = (state_nxt != PM_SLEEP);
    mosc_d = (state_nxt != PM_SLEEP);
    fscm_d = (state_nxt != PM_SLEEP);
    lprc_d = (state_nxt != PM_SLEEP) | wdt_enable;
    clr_d  = enter_sleep & wdt_enable;
    wake_d = leave_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= 1'b1;
      main_osc_en   <= 1'b1;
      lprc_osc_en   <= 1'b1;
      fscm_en       <= 1'b1;
      wdt_clr       <= 1'b0;
      wake          <= 1'b1;
    end else begin
      cpu_clk_en    <= cpu_d;
      periph_clk_en <= per_d;
      main_osc_en   <= mosc_d;
      lprc_osc_en   <= lprc_d;
      fscm_en       <= fscm_d;
      wdt_clr       <= clr_d;
      wake          <= wake_d;
    end
  end
endmodule

// File: rtl/pwr_osc_hold.sv
module pwr_osc_hold
  import pwr_mode_pkg::*;
#(
  parameter int unsigned       OSC_W   = 3,
  parameter logic [OSC_W-1:0] OSC_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pm_state_e        state_q,
  input  logic [OSC_W-1:0] osc_req,
  output logic [OSC_W-1:0] osc_sel
);
  logic osc_load;

  assign osc_load = (state_q == PM_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        osc_sel <= OSC_RST;
    else if (osc_load) osc_sel <= osc_req;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned       N_SRC   = 8,
  parameter int unsigned       OSC_W   = 3,
  parameter logic [OSC_W-1:0] OSC_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic [OP_W-1:0]  save_op,
  input  logic [N_SRC-1:0] irq_pend,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             wdt_timeout,
  input  logic             wdt_enable,
  input  logic [OSC_W-1:0] osc_req,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             main_osc_en,
  output logic             lprc_osc_en,
  output logic             fscm_en,
  output logic             wdt_clr,
  output logic             wake,
  output logic [OSC_W-1:0] osc_sel
);
  logic      rst_meta_n, rst_core_n;
  logic      irq_wake, enter_sleep, leave_low;
  pm_state_e state_q, state_nxt;

  // asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  pwr_wake_detect #(.N_SRC(N_SRC)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .irq_wake (irq_wake)
  );

  pwr_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .save_req    (save_req),
    .save_op     (save_op),
    .irq_wake    (irq_wake),
    .wdt_timeout (wdt_timeout),
    .state_q     (state_q),
    .state_nxt   (state_nxt),
    .enter_sleep (enter_sleep),
    .leave_low   (leave_low)
  );

  pwr_gate_decode u_gate (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .state_nxt     (state_nxt),
    .wdt_enable    (wdt_enable),
    .enter_sleep   (enter_sleep),
    .leave_low     (leave_low),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .main_osc_en   (main_osc_en),
    .lprc_osc_en   (lprc_osc_en),
    .fscm_en       (fscm_en),
    .wdt_clr       (wdt_clr),
    .wake          (wake)
  );

  pwr_osc_hold #(.OSC_W(OSC_W), .OSC_RST(OSC_RST)) u_osc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .state_q (state_q),
    .osc_req (osc_req),
    .osc_sel (osc_sel)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             save_req,
  input logic [OP_W-1:0]  save_op,
  input logic [N_SRC-1:0] irq_pend,
  input logic [N_SRC-1:0] irq_en,
  input logic             wdt_timeout,
  input logic             wdt_enable,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             main_osc_en,
  input logic             lprc_osc_en,
  input logic             fscm_en,
  input logic             wdt_clr,
  input logic             wake
);
  logic any_hit, valid_req;
  assign any_hit   = |(irq_pend & irq_en);
  assign valid_req = save_req && (save_op == OP_SLEEP || save_op == OP_IDLE);

  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && save_req && save_op == OP_SLEEP && !any_hit
    |=> !cpu_clk_en && !periph_clk_en && !main_osc_en && !fscm_en); // R2

  AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && save_req && save_op == OP_IDLE && !any_hit
    |=> !cpu_clk_en && periph_clk_en && main_osc_en && fscm_en && lprc_osc_en && !wdt_clr); // R3

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && !valid_req |=> cpu_clk_en); // R9

  AST_CLR_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |-> !main_osc_en && lprc_osc_en); // R5

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr); // R5

  AST_LPRC_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en && !wdt_timeout && !any_hit
    |=> lprc_osc_en == $past(wdt_enable)); // R6

  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en && (wdt_timeout || any_hit) |=> cpu_clk_en && wake); // R7

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R7

  AST_NO_FALSE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en && !wdt_timeout && !any_hit |=> !cpu_clk_en && !wake); // R8

  AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && any_hit |=> cpu_clk_en && !wdt_clr); // R10
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .save_req      (save_req),
  .save_op       (save_op),
  .irq_pend      (irq_pend),
  .irq_en        (irq_en),
  .wdt_timeout   (wdt_timeout),
  .wdt_enable    (wdt_enable),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .main_osc_en   (main_osc_en),
  .lprc_osc_en   (lprc_osc_en),
  .fscm_en       (fscm_en),
  .wdt_clr       (wdt_clr),
  .wake          (wake)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [3:0] rq;
    logic       req;
    logic [1:0] op;
    logic [7:0] pend;
    logic [7:0] en;
    logic       wto;
    logic       wen;
    logic [2:0] osc;
    logic [6:0] exp_g;   // {cpu, periph, mosc, lprc, fscm, wdt_clr, wake}
    logic [2:0] exp_osc;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd11, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 7'b1111100, 3'd2}, // R11 track
    '{4'd4,  1'b1, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 7'b1111100, 3'd2}, // R4 code 00
    '{4'd4,  1'b1, 2'b11, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 7'b1111100, 3'd2}, // R4 code 11
    '{4'd9,  1'b0, 2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 3'd2, 7'b1111100, 3'd2}, // R9
    '{4'd2,  1'b1, 2'b01, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 7'b0001010, 3'd2}, // R2 R5 entry
    '{4'd11, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0001000, 3'd2}, // R11 hold
    '{4'd8,  1'b0, 2'b00, 8'h01, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0001000, 3'd2}, // R8
    '{4'd8,  1'b0, 2'b00, 8'h01, 8'h02, 1'b0, 1'b1, 3'd5, 7'b0001000, 3'd2}, // R8
    '{4'd13, 1'b1, 2'b10, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0001000, 3'd2}, // R13
    '{4'd7,  1'b0, 2'b00, 8'h04, 8'h04, 1'b0, 1'b1, 3'd5, 7'b1111101, 3'd2}, // R7 R11 wake
    '{4'd11, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b1111100, 3'd5}, // R11 R7
    '{4'd3,  1'b1, 2'b10, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0111100, 3'd5}, // R3
    '{4'd7,  1'b0, 2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 3'd5, 7'b1111101, 3'd5}, // R7 wdt
    '{4'd7,  1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b1111100, 3'd5}, // R7
    '{4'd5,  1'b1, 2'b01, 8'h00, 8'h00, 1'b0, 1'b0, 3'd5, 7'b0000000, 3'd5}, // R5 no clr
    '{4'd6,  1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b0, 3'd5, 7'b0000000, 3'd5}, // R6
    '{4'd6,  1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0001000, 3'd5}, // R6
    '{4'd7,  1'b0, 2'b00, 8'h00, 8'h00, 1'b1, 1'b1, 3'd5, 7'b1111101, 3'd5}, // R7
    '{4'd10, 1'b1, 2'b01, 8'h80, 8'h80, 1'b0, 1'b1, 3'd5, 7'b1111100, 3'd5}, // R10
    '{4'd10, 1'b0, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b1111100, 3'd5}, // R10
    '{4'd8,  1'b1, 2'b10, 8'h01, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0111100, 3'd5}, // R8
    '{4'd13, 1'b1, 2'b01, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 7'b0111100, 3'd5}, // R13
    '{4'd7,  1'b0, 2'b00, 8'h02, 8'h02, 1'b0, 1'b1, 3'd5, 7'b1111101, 3'd5}  // R7
  };

  logic       clk;
  logic       rst_n;
  logic       save_req;
  logic [1:0] save_op;
  logic [7:0] irq_pend, irq_en;
  logic       wdt_timeout, wdt_enable;
  logic [2:0] osc_req;
  logic       cpu_clk_en, periph_clk_en, main_osc_en, lprc_osc_en, fscm_en;
  logic       wdt_clr, wake;
  logic [2:0] osc_sel;

  int total = 0;
  int bad   = 0;

  pwr_mode_ctrl uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .save_req      (save_req),
    .save_op       (save_op),
    .irq_pend      (irq_pend),
    .irq_en        (irq_en),
    .wdt_timeout   (wdt_timeout),
    .wdt_enable    (wdt_enable),
    .osc_req       (osc_req),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .main_osc_en   (main_osc_en),
    .lprc_osc_en   (lprc_osc_en),
    .fscm_en       (fscm_en),
    .wdt_clr       (wdt_clr),
    .wake          (wake),
    .osc_sel       (osc_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] outs();
    return {cpu_clk_en, periph_clk_en, main_osc_en, lprc_osc_en, fscm_en,
            wdt_clr, wake, osc_sel};
  endfunction

  task automatic chk(input string rq, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic idle_inputs();
    save_req    = 1'b0;
    save_op     = 2'b00;
    irq_pend    = '0;
    irq_en      = '0;
    wdt_timeout = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    wdt_enable = 1'b1;
    osc_req    = 3'd0;
    idle_inputs();
    #(CLK_PERIOD * 2 + 1);
    chk("R1 in reset", outs(), {7'b1111101, 3'd0});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", outs(), {7'b1111100, 3'd0});

    // table walk: drive at a falling edge, check at the next one
    for (int i = 0; i < NV; i++) begin
      save_req    = VEC[i].req;
      save_op     = VEC[i].op;
      irq_pend    = VEC[i].pend;
      irq_en      = VEC[i].en;
      wdt_timeout = VEC[i].wto;
      wdt_enable  = VEC[i].wen;
      osc_req     = VEC[i].osc;
      @(negedge clk);
      chk($sformatf("R%0d row %0d", VEC[i].rq, i), outs(),
          {VEC[i].exp_g, VEC[i].exp_osc});
    end

    // R12: asynchronous reset out of Sleep
    idle_inputs();
    save_req = 1'b1;
    save_op  = 2'b01;
    @(negedge clk);
    idle_inputs();
    chk("R12 asleep", outs(), {7'b0001010, 3'd5});
    #2 rst_n = 1'b0;
    #1 chk("R12 forced run", outs(), {7'b1111101, 3'd0});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 after release", outs(), {7'b1111100, 3'd5});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule